// File: doc/BRIEF.md
# Asynchronous Interrupt Arbiter

This block watches the asynchronous interrupt sources of a core and decides, cycle by cycle, whether one of them should be taken and which one. There are three sources. The first is an imprecise floating-point condition, built from the status word. The second is a level-sensitive external request line. The third is a one-cycle timer underflow tick.

When a source wins, the block raises a one-cycle `take_o` strobe. With the strobe it presents the vector offset, a mask of extra bits that the entry logic ORs into the saved machine state, and the return address. The return address is the program counter of the next instruction not yet executed.

The register update itself belongs to a separate exception entry unit. After any strobe the arbiter stays idle until that unit has written the machine state to its entry value, with the external enable and both floating-point mode bits at zero. Only then does it evaluate again, so two deliveries can never overlap.

Top module: `irq_pend_arb`

## Requirements
- R1: After reset `take_o` is 0 and stays 0 while no source is active.
- R2: The external line passes through two synchronizing flops. With `msr_ee_i` high and the line rising just after edge 0, `take_o` is 0 after edges 1 and 2 and is 1 after edge 3.
- R3: External pending is a level. Taking the external interrupt does not clear it. If the line is still high when `msr_ee_i` returns to 1, the block delivers vector 0x500 again.
- R4: When the external line falls before `msr_ee_i` is set, the external pending is gone and nothing is delivered.
- R5: Timer pending is one-shot. A tick is delivered once, and re-enabling `msr_ee_i` afterwards gives no second delivery.
- R6: A timer tick that arrives while `msr_ee_i` is 0 stays pending. It is delivered to vector 0x900 once `msr_ee_i` is set.
- R7: External beats timer. With both pending, vector 0x500 is taken and the timer stays pending. The timer is delivered after the line falls and `msr_ee_i` is set again.
- R8: The floating-point condition is (`msr_fe0_i` OR `msr_fe1_i`) AND `fpsum_i`. It beats every other source and is taken even with `msr_ee_i` at 0. It delivers to vector 0x700 with `srr_or_o` bit 20 (floating-point enabled) and bit 16 (subsequent instruction) set and all other bits 0.
- R9: On a strobe, `save_pc_o` equals `pc_i` from the cycle in which the decision was made.
- R10: After a strobe, no further strobe occurs until `msr_ee_i`, `msr_fe0_i` and `msr_fe1_i` have all been seen at 0.
- R11: External and timer deliveries present `srr_or_o` as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_line_i | input | 1 | Asynchronous level external request |
| dec_tick_i | input | 1 | One-cycle timer underflow pulse |
| msr_ee_i | input | 1 | External interrupt enable |
| msr_fe0_i | input | 1 | Floating-point exception mode bit 0 |
| msr_fe1_i | input | 1 | Floating-point exception mode bit 1 |
| fpsum_i | input | 1 | Floating-point enabled-exception summary |
| pc_i | input | PC_W | Address of the next instruction |
| take_o | output | 1 | Delivery strobe, one cycle |
| vec_o | output | 12 | Vector offset (0x700, 0x500 or 0x900) |
| srr_or_o | output | SRR_W | Bits to OR into the saved state |
| save_pc_o | output | PC_W | Return address to save |

## Verification
The external line is driven in several ways. In one run it is held across a delivery and a re-enable, which shows that its pending is a level. In another it is dropped before enable, which shows that the pending clears with the line. In a third it is raised against an enabled core, which measures the two-flop latency.

Timer ticks are given with the enable off, then re-enabled twice, which separates one-shot behaviour from level behaviour. Overlapping ext+timer and ext+floating-point cases confirm the priority order and that the loser is still pending afterwards. Holding the machine state unchanged after a strobe shows that no second delivery is issued before the entry update.

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
  parameter int PC_W     = 32,
  parameter int SRR_W    = 32,
  parameter int FPEN_POS = 20,
  parameter int NEXT_POS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_line_i,
  input  logic             dec_tick_i,
  input  logic             msr_ee_i,
  input  logic             msr_fe0_i,
  input  logic             msr_fe1_i,
  input  logic             fpsum_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic             take_o,
  output logic [11:0]      vec_o,
  output logic [SRR_W-1:0] srr_or_o,
  output logic [PC_W-1:0]  save_pc_o
);
  localparam logic [11:0] VEC_FP  = 12'h700;
  localparam logic [11:0] VEC_EXT = 12'h500;
  localparam logic [11:0] VEC_DEC = 12'h900;
  localparam logic [SRR_W-1:0] FP_MASK =
    (SRR_W'(1) << FPEN_POS) | (SRR_W'(1) << NEXT_POS);

  logic sync1, ext_pend, dec_pend, busy_q;
  logic fp_cond, ext_go, dec_go, want, quiet;

  assign fp_cond = (msr_fe0_i | msr_fe1_i) & fpsum_i;
  assign ext_go  = msr_ee_i & ext_pend;
  assign dec_go  = msr_ee_i & dec_pend & ~ext_pend;
  assign want    = ~busy_q & (fp_cond | ext_go | dec_go);
  assign quiet   = ~msr_ee_i & ~msr_fe0_i & ~msr_fe1_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1    <= 1'b0;
      ext_pend <= 1'b0;
    end else begin
      sync1    <= ext_line_i;
      ext_pend <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      dec_pend <= 1'b0;
    else if (dec_tick_i)
      dec_pend <= 1'b1;
    else if (want && !fp_cond && !ext_go)
      dec_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      busy_q <= 1'b0;
    else if (want)
      busy_q <= 1'b1;
    else if (quiet)
      busy_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_o    <= 1'b0;
      vec_o     <= '0;
      srr_or_o  <= '0;
      save_pc_o <= '0;
    end else begin
      take_o <= want;
      if (want) begin
        save_pc_o <= pc_i;
        if (fp_cond) begin
          vec_o    <= VEC_FP;
          srr_or_o <= FP_MASK;
        end else begin
          vec_o    <= ext_go ? VEC_EXT : VEC_DEC;
          srr_or_o <= '0;
        end
      end
    end
  end

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o); // R10
  AST_MISSED_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_pend && msr_ee_i && !busy_q) |=> take_o); // R3
  AST_DEC_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o == VEC_DEC && !$past(dec_tick_i)) |-> !dec_pend); // R5
  AST_FP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && $past(fp_cond)) |-> (vec_o == VEC_FP && srr_or_o == FP_MASK)); // R8
  AST_PLAIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o != VEC_FP) |-> srr_or_o == '0); // R11
endmodule

// File: tb/irq_pend_arb_test.sv
module irq_pend_arb_test;
  localparam int PC_W = 32;
  localparam logic [31:0] FPM = (32'd1 << 20) | (32'd1 << 16);

  typedef struct {
    logic [11:0] vec;
    logic [31:0] srr;
    logic [PC_W-1:0] pc;
    string tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic ext_line_i = 0, dec_tick_i = 0, msr_ee_i = 0, msr_fe0_i = 0, msr_fe1_i = 0, fpsum_i = 0;
  logic [PC_W-1:0] pc_i = '0;
  logic take_o;
  logic [11:0] vec_o;
  logic [31:0] srr_or_o;
  logic [PC_W-1:0] save_pc_o;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  item_t q[$];

  irq_pend_arb uut (.clk(clk), .rst_n(rst_n), .ext_line_i(ext_line_i), .dec_tick_i(dec_tick_i),
    .msr_ee_i(msr_ee_i), .msr_fe0_i(msr_fe0_i), .msr_fe1_i(msr_fe1_i), .fpsum_i(fpsum_i),
    .pc_i(pc_i), .take_o(take_o), .vec_o(vec_o), .srr_or_o(srr_or_o), .save_pc_o(save_pc_o));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [11:0] v, input logic [31:0] s, input logic [PC_W-1:0] p, input string t);
    item_t it;
    it.vec = v; it.srr = s; it.pc = p; it.tag = t;
    q.push_back(it);
  endtask

  task automatic wcyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drained(input string req);
    chk(q.size() == 0, req, q.size(), 0);
    q.delete();
  endtask

  task automatic ack();
    msr_ee_i = 0; msr_fe0_i = 0; msr_fe1_i = 0; fpsum_i = 0;
    wcyc(3);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n && take_o) begin
      if (q.size() == 0) begin
        chk(0, "R10 unexpected strobe", vec_o, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(vec_o == it.vec, {it.tag, " vector"}, vec_o, it.vec);
        chk(srr_or_o == it.srr, {it.tag, " srr mask R11"}, srr_or_o, it.srr);
        chk(save_pc_o == it.pc, {it.tag, " saved pc R9"}, save_pc_o, it.pc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      chk(0, "watchdog", cyc, 0);
      summary();
    end
  end

  initial begin
    wcyc(3);
    rst_n = 1;
    wcyc(3);
    chk(take_o == 0, "R1 reset idle", take_o, 0);

    // R8 fp condition with enable off; R10 no repeat while state unchanged
    pc_i = 32'h100; push(12'h700, FPM, 32'h100, "R8 fp");
    msr_fe0_i = 1; fpsum_i = 1;
    wcyc(8);
    drained("R10 single delivery");
    ack();

    // R2 latency through synchronizer
    msr_ee_i = 1; pc_i = 32'h200; push(12'h500, 0, 32'h200, "R2 ext");
    ext_line_i = 1;
    wcyc(2);
    chk(take_o == 0, "R2 no strobe before sync", take_o, 0);
    wcyc(1);
    chk(take_o == 1, "R2 strobe after sync", take_o, 1);
    wcyc(3);
    drained("R2 ext delivered");
    ack();

    // R3 level persists
    pc_i = 32'h240; push(12'h500, 0, 32'h240, "R3 ext again");
    msr_ee_i = 1;
    wcyc(4);
    drained("R3 level pending");
    ack();

    // R4 deassert clears
    ext_line_i = 0; wcyc(4);
    msr_ee_i = 1; wcyc(6);
    drained("R4 no delivery after drop");
    msr_ee_i = 0; wcyc(2);

    // R6 timer held while disabled
    dec_tick_i = 1; wcyc(1); dec_tick_i = 0;
    wcyc(5);
    drained("R6 held while disabled");
    pc_i = 32'h300; push(12'h900, 0, 32'h300, "R6 timer");
    msr_ee_i = 1; wcyc(4);
    drained("R6 timer delivered");
    ack();

    // R5 one-shot
    msr_ee_i = 1; wcyc(6);
    drained("R5 no second timer");
    msr_ee_i = 0; wcyc(2);

    // R7 ext beats timer, timer survives
    ext_line_i = 1; dec_tick_i = 1; wcyc(1); dec_tick_i = 0; wcyc(4);
    pc_i = 32'h400; push(12'h500, 0, 32'h400, "R7 ext first");
    msr_ee_i = 1; wcyc(4);
    drained("R7 ext first");
    ack();
    ext_line_i = 0; wcyc(4);
    pc_i = 32'h440; push(12'h900, 0, 32'h440, "R7 timer after");
    msr_ee_i = 1; wcyc(4);
    drained("R7 timer after");
    ack();

    // R8 fp beats ext; ext still pending after
    ext_line_i = 1; wcyc(4);
    pc_i = 32'h500; push(12'h700, FPM, 32'h500, "R8 fp over ext");
    msr_fe1_i = 1; fpsum_i = 1; msr_ee_i = 1;
    wcyc(4);
    drained("R8 fp over ext");
    ack();
    pc_i = 32'h540; push(12'h500, 0, 32'h540, "R7 ext kept after fp");
    msr_ee_i = 1; wcyc(4);
    drained("R7 ext kept after fp");
    ack();
    ext_line_i = 0; wcyc(4);

    done = 1;
    summary();
  end
endmodule